// File: doc/BRIEF.md
# Sizable Base Address Register

This block holds the base address of one device resource in configuration space, in a form that system software can size. Software writes all ones to the register and reads it back. Only the address bits at and above the block-size boundary are stored, and every bit below that boundary reads as zero. The complement of the readback, plus one, therefore gives the block size. The low bits carry the type of space, so software can tell how to place the resource.

A parameter picks one of four variants:

- 32-bit memory.
- 64-bit memory, which uses two adjacent dwords.
- I/O space.
- Expansion-ROM base, which has a software-controlled decode enable.

A second parameter gives the block size as a power of two. A third marks memory as prefetchable.

Besides the configuration side, the block compares an incoming bus address against the programmed base and raises a hit output. The configuration side uses plain strobes rather than a stream handshake:

- A write with `cfg_we` high is always accepted at the next clock edge. There is no back-pressure.
- Reads are combinational from `rd_sel`.

Top module: `cfg_bar`

## Requirements
- R1: In the memory variants, the low dword reads bit 0 = 0, bits 2:1 = 00 for 32-bit or 10 for 64-bit, and bit 3 = the prefetchable parameter. Writes never change these bits.
- R2: Written address bits at or above the size boundary read back as written. Address bits below the boundary, other than the flag bits, read as 0, so an all-ones write to a 1 MB 32-bit memory register reads back 0xFFF00000.
- R3: In the I/O variant, bit 0 reads 1 and bit 1 reads 0. The size is held between 4 and 256 bytes, and writing all ones to a 64-byte register reads back 0xFFFFFFC1.
- R4: In the 64-bit variant, the upper dword (`rd_sel`/`cfg_sel` = 1) is fully writable for block sizes up to 4 GB. In every other variant, that dword reads 0 and ignores writes.
- R5: In the ROM variant, bit 0 is a writable decode enable and bits 10:1 read 0. Base bits start no lower than bit 11, so the granularity is 2 KB.
- R6: After reset, every writable bit reads 0 and only the fixed flag bits remain.
- R7: `bus_hit` is high exactly when the 64-bit `bus_addr` masked to the bits at and above the size boundary equals the programmed base. For 32-bit variants, the upper base dword is zero, so `bus_addr[63:32]` must be zero for a hit.
- R8: In the ROM variant, `bus_hit` additionally requires the decode enable (bit 0 of the low dword) to be 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target dword: 0 low, 1 high |
| cfg_wdata | input | 32 | Write data |
| rd_sel | input | 1 | Read dword select: 0 low, 1 high |
| rd_data | output | 32 | Read data for the selected dword |
| bus_addr | input | 64 | Bus address to decode |
| bus_hit | output | 1 | Address falls in the programmed block |

## Verification
The hardest state to reach from the ports is a hit near the block boundary. In the 64-bit variant, a hit needs both dwords programmed consistently with the address. In the ROM variant, it also needs the enable bit set. Random addresses almost never land inside the block. The stimulus therefore builds most addresses from the bench's own model of the programmed base, adds random offsets below the boundary, and sometimes flips a single bit above the boundary or in the upper dword to probe the miss side.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;

  typedef enum logic [1:0] {
    KIND_MEM32 = 2'd0,
    KIND_MEM64 = 2'd1,
    KIND_IO    = 2'd2,
    KIND_ROM   = 2'd3
  } bar_kind_e;

  // Clamp a requested size exponent to the legal range of a variant.
  function automatic int eff_log2(bar_kind_e kind, int req);
    int lo;
    int hi;
    case (kind)
      KIND_IO:    begin lo = 2;  hi = 8;  end
      KIND_ROM:   begin lo = 11; hi = 31; end
      KIND_MEM64: begin lo = 4;  hi = 63; end
      default:    begin lo = 4;  hi = 31; end
    endcase
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Mask of address bits at and above the size boundary.
  function automatic logic [63:0] addr_mask(int l2);
    return ~((64'd1 << l2) - 64'd1);
  endfunction

endpackage

// File: rtl/cfg_bar_dword.sv
module cfg_bar_dword #(
  parameter logic [31:0] WMASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] q
);
  // Only the bits in WMASK are stored; all others stay zero.
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & WMASK;
  end
endmodule

// File: rtl/cfg_bar_match.sv
module cfg_bar_match #(
  parameter logic [63:0] AMASK  = 64'hFFFF_FFFF_FFFF_F000,
  parameter bit          NEED_EN = 1'b0
) (
  input  logic [31:0] lo_q,
  input  logic [31:0] hi_q,
  input  logic [63:0] bus_addr,
  output logic        hit
);
  logic [63:0] base;
  logic        addr_eq;

  always_comb begin
    base    = {hi_q, lo_q} & AMASK;
    addr_eq = ((bus_addr & AMASK) == base);
    hit     = addr_eq && (!NEED_EN || lo_q[0]);
  end
endmodule

// File: rtl/cfg_bar_rdmux.sv
module cfg_bar_rdmux #(
  parameter logic [31:0] RO_LO = 32'h0
) (
  input  logic        rd_sel,
  input  logic [31:0] lo_q,
  input  logic [31:0] hi_q,
  output logic [31:0] rd_data
);
  always_comb begin
    if (rd_sel) rd_data = hi_q;
    else        rd_data = lo_q | RO_LO;
  end
endmodule

// File: rtl/cfg_bar.sv
module cfg_bar
  import cfg_bar_pkg::*;
#(
  parameter bar_kind_e KIND      = KIND_MEM32,
  parameter int        SIZE_LOG2 = 20,
  parameter bit        PREFETCH  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  input  logic [63:0] bus_addr,
  output logic        bus_hit
);
  localparam int          L        = eff_log2(KIND, SIZE_LOG2);
  localparam bit          IS64     = (KIND == KIND_MEM64);
  localparam bit          IS_IO    = (KIND == KIND_IO);
  localparam bit          IS_ROM   = (KIND == KIND_ROM);
  localparam logic [63:0] AMASK    = addr_mask(L);
  localparam logic [31:0] LO_WMASK = AMASK[31:0] | (IS_ROM ? 32'd1 : 32'd0);
  localparam logic [31:0] HI_WMASK = IS64 ? AMASK[63:32] : 32'd0;
  localparam logic [31:0] RO_LO    = IS_IO  ? 32'h1 :
                                     IS_ROM ? 32'h0 :
                                     {28'd0, PREFETCH, IS64, 2'b00};

  logic [31:0] lo_q;
  logic [31:0] hi_q;

  cfg_bar_dword #(.WMASK(LO_WMASK)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we && !cfg_sel),
    .wdata (cfg_wdata),
    .q     (lo_q)
  );

  generate
    if (IS64) begin : g_hi
      cfg_bar_dword #(.WMASK(HI_WMASK)) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we && cfg_sel),
        .wdata (cfg_wdata),
        .q     (hi_q)
      );
    end else begin : g_nohi
      assign hi_q = 32'd0;
    end
  endgenerate

  cfg_bar_rdmux #(.RO_LO(RO_LO)) u_rd (
    .rd_sel  (rd_sel),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .rd_data (rd_data)
  );

  cfg_bar_match #(.AMASK(AMASK), .NEED_EN(IS_ROM)) u_match (
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .bus_addr (bus_addr),
    .hit      (bus_hit)
  );
endmodule

// File: rtl/cfg_bar_chk.sv
module cfg_bar_chk
  import cfg_bar_pkg::*;
#(
  parameter bar_kind_e KIND      = KIND_MEM32,
  parameter int        SIZE_LOG2 = 20,
  parameter bit        PREFETCH  = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        rd_sel,
  input logic [31:0] rd_data,
  input logic [63:0] bus_addr,
  input logic        bus_hit
);
  localparam int          L      = eff_log2(KIND, SIZE_LOG2);
  localparam bit          IS64   = (KIND == KIND_MEM64);
  localparam bit          IS_MEM = (KIND == KIND_MEM32) || IS64;
  localparam bit          IS_IO  = (KIND == KIND_IO);
  localparam bit          IS_ROM = (KIND == KIND_ROM);
  localparam logic [63:0] AM     = addr_mask(L);
  localparam logic [31:0] WM     = AM[31:0] | (IS_ROM ? 32'd1 : 32'd0);
  localparam logic [31:0] FLAGS  = IS_MEM ? 32'hF : IS_IO ? 32'h3 : 32'h0;

  a_r1_mem_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_MEM && !rd_sel) |-> (rd_data[3:0] == {PREFETCH, IS64, 2'b00}));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (rd_sel || (((rd_data ^ $past(cfg_wdata)) & WM) == 32'd0)));

  // R2 and R5: undecoded and reserved bits read zero
  a_r2_undecoded_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> ((rd_data & ~WM & ~FLAGS) == 32'd0));

  a_r3_io_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_IO && !rd_sel) |-> (rd_data[1:0] == 2'b01));

  a_r4_hi_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS64 && rd_sel) |-> (rd_data == 32'd0));

  a_r8_rom_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_ROM && bus_hit && !rd_sel) |-> rd_data[0]);
endmodule

bind cfg_bar cfg_bar_chk #(.KIND(KIND), .SIZE_LOG2(SIZE_LOG2), .PREFETCH(PREFETCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .bus_addr  (bus_addr),
  .bus_hit   (bus_hit)
);

// File: tb/sim_cfg_bar.sv
`timescale 1ns/1ps
module sim_cfg_bar;
  import cfg_bar_pkg::*;

  // Four variants driven from one shared stimulus:
  // 0: 32-bit memory 1 MB, 1: 64-bit prefetchable memory 4 KB,
  // 2: I/O 64 bytes, 3: ROM 64 KB.
  localparam int NI = 4;
  localparam int LG [NI] = '{20, 12, 6, 16};
  localparam bar_kind_e KD [NI] = '{KIND_MEM32, KIND_MEM64, KIND_IO, KIND_ROM};
  localparam bit PF [NI] = '{1'b0, 1'b1, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_sel = 1'b0;
  logic [63:0] bus_addr = '0;
  logic [31:0] rdv [NI];
  logic        hitv [NI];

  logic [31:0] m_lo [NI];
  logic [31:0] m_hi [NI];
  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfg_bar #(.KIND(KD[0]), .SIZE_LOG2(LG[0]), .PREFETCH(PF[0])) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rdv[0]), .bus_addr(bus_addr), .bus_hit(hitv[0]));
  cfg_bar #(.KIND(KD[1]), .SIZE_LOG2(LG[1]), .PREFETCH(PF[1])) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rdv[1]), .bus_addr(bus_addr), .bus_hit(hitv[1]));
  cfg_bar #(.KIND(KD[2]), .SIZE_LOG2(LG[2]), .PREFETCH(PF[2])) u2 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rdv[2]), .bus_addr(bus_addr), .bus_hit(hitv[2]));
  cfg_bar #(.KIND(KD[3]), .SIZE_LOG2(LG[3]), .PREFETCH(PF[3])) u3 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rdv[3]), .bus_addr(bus_addr), .bus_hit(hitv[3]));

  // Reference model derived from the requirements.
  function automatic logic [63:0] amask(int k);
    return ~((64'd1 << LG[k]) - 64'd1);
  endfunction

  function automatic logic [31:0] wm_lo(int k);
    logic [63:0] a;
    a = amask(k);
    return a[31:0] | ((KD[k] == KIND_ROM) ? 32'd1 : 32'd0);   // R5 enable bit
  endfunction

  function automatic logic [31:0] wm_hi(int k);
    return (KD[k] == KIND_MEM64) ? 32'hFFFF_FFFF : 32'd0;     // R4
  endfunction

  function automatic logic [31:0] ro_lo(int k);
    if (KD[k] == KIND_IO)  return 32'h1;                      // R3
    if (KD[k] == KIND_ROM) return 32'h0;
    return {28'd0, PF[k], KD[k] == KIND_MEM64, 2'b00};        // R1
  endfunction

  function automatic logic [31:0] exp_rd(int k, logic sel);
    return sel ? m_hi[k] : (m_lo[k] | ro_lo(k));
  endfunction

  function automatic logic exp_hit(int k, logic [63:0] a);
    logic [63:0] base;
    base = {m_hi[k], m_lo[k]} & amask(k);
    return ((a & amask(k)) == base) && ((KD[k] != KIND_ROM) || m_lo[k][0]);   // R7, R8
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    for (int k = 0; k < NI; k++) begin
      if (sel) m_hi[k] = d & wm_hi(k);
      else     m_lo[k] = d & wm_lo(k);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_reads(input string req);
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      rd_sel = s[0];
      #1;
      for (int k = 0; k < NI; k++)
        chk(rdv[k] == exp_rd(k, s[0]), req, {32'd0, rdv[k]}, {32'd0, exp_rd(k, s[0])});
    end
  endtask

  task automatic check_hit(input logic [63:0] a, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    for (int k = 0; k < NI; k++)
      chk(hitv[k] == exp_hit(k, a), req, {63'd0, hitv[k]}, {63'd0, exp_hit(k, a)});
  endtask

  task automatic run_all();
    logic [63:0] a;
    int k;
    for (int i = 0; i < NI; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_reads("R6 reset state R1 R3 R4");
    do_write(1'b0, 32'hFFFF_FFFF);
    check_reads("R2 all-ones sizing R3 R5");
    // Directed sizing values
    @(negedge clk); rd_sel = 1'b0; #1;
    chk(rdv[0] == 32'hFFF0_0000, "R2 1MB readback", {32'd0, rdv[0]}, 64'hFFF0_0000);
    chk(rdv[2] == 32'hFFFF_FFC1, "R3 io readback", {32'd0, rdv[2]}, 64'hFFFF_FFC1);
    chk(rdv[3] == 32'hFFFF_0001, "R5 rom readback", {32'd0, rdv[3]}, 64'hFFFF_0001);
    do_write(1'b1, 32'hFFFF_FFFF);
    check_reads("R4 upper dword");
    do_write(1'b1, 32'd0);
    // ROM enable gating
    do_write(1'b0, 32'hABCD_0000);
    check_hit(64'h0000_0000_ABCD_1234, "R8 rom disabled");
    do_write(1'b0, 32'hABCD_0001);
    check_hit(64'h0000_0000_ABCD_1234, "R8 rom enabled R7");
    check_hit(64'h0000_0001_ABCD_1234, "R7 upper address bits");
    check_hit(64'h0000_0000_ABCE_0000, "R7 boundary miss");
    // Constrained random mix
    for (int it = 0; it < 600; it++) begin
      case ($urandom % 4)
        0: do_write($urandom % 2, $urandom);
        1: check_reads("R2 random readback R1");
        default: begin
          k = $urandom % NI;
          a = {m_hi[k], m_lo[k]} & amask(k);
          a = a | ({$urandom, $urandom} & ~amask(k));
          case ($urandom % 4)
            0: a[LG[k] + ($urandom % (32 - LG[k]))] ^= 1'b1;
            1: a[32 + ($urandom % 32)] ^= 1'b1;
            default: ;
          endcase
          check_hit(a, "R7 random address R8");
        end
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule